// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block lets a microprocessor that puts address and data on the same eight wires reach an internal register file. The processor first presents a register address and pulses an address-latch strobe. It then performs either a write strobe or a read strobe while its chip select is held low. The block turns this bus traffic into a simple register-file port. That port has a latched address, a one-cycle write pulse with write data, and a one-cycle read request that the register file answers with a data-valid pulse some time later.

Every bus input is asynchronous to the block's fast system clock. Each passes through a two-flop synchronizer, and strobe edges are found by comparing consecutive synchronized samples. During a read, the block pulls an active-low ready line low so that the processor waits. It drives the fetched data onto the shared lines and then raises ready. It releases the lines as soon as the read strobe or chip select goes away. The pads are modelled as separate input, output and output-enable signals for both the data lines and the ready line.

Top module: `mux_bus_slave`

## Requirements
- R1: While reset is asserted, and after reset with the bus idle, `bus_ad_oe`, `bus_rdy_oe`, `reg_wr` and `reg_rd` are all 0, even if chip select is already low.
- R2: The register address is the value on `bus_ad_in` at the falling edge of `bus_ale`. Changes on `bus_ad_in` after that edge do not alter `reg_addr` for the access that follows.
- R3: A rising edge of `bus_wr_n` while `bus_cs_n` is low gives exactly one cycle of `reg_wr`. In that cycle `reg_addr` holds the latched address and `reg_wdata` holds the value `bus_ad_in` had at the edge.
- R4: A write strobe while `bus_cs_n` is high produces no `reg_wr`, and the register it targets keeps its old value.
- R5: A falling edge of `bus_rd_n` while `bus_cs_n` is low gives exactly one cycle of `reg_rd`, with `reg_addr` equal to the latched address.
- R6: From the cycle of `reg_rd` until `reg_rvalid` arrives, `bus_rdy` is 0 (wait), for any response latency.
- R7: After `reg_rvalid`, `bus_rdy` returns to 1, `bus_ad_oe` is 1, and `bus_ad_out` equals the `reg_rdata` captured with that pulse.
- R8: `bus_ad_oe` is 1 only during a read with both chip select and read strobe low. It returns to 0 within four clock cycles of `bus_rd_n` rising.
- R9: `bus_rdy_oe` is 1 while the synchronized chip select is low and 0 while it is high.
- R10: A `reg_rvalid` pulse that arrives when no read is waiting has no effect. `bus_ad_oe` stays 0, and the next read still waits with `bus_rdy` low for its own response.
- R11: Raising `bus_cs_n` while a read waits aborts it. `bus_ad_oe` and `bus_rdy_oe` drop to 0 without waiting for the response.
- R12: Chip select may stay low across any series of back-to-back reads and writes. Each access yields exactly one register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ale | input | 1 | Address latch strobe, address taken on its falling edge |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low, data taken on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_ad_in | input | BUS_W | Shared address/data lines as received |
| bus_ad_out | output | BUS_W | Read data for the shared lines |
| bus_ad_oe | output | 1 | Output enable of the shared lines |
| bus_rdy | output | 1 | Ready level, 0 asks the master to wait |
| bus_rdy_oe | output | 1 | Output enable of the ready line |
| reg_addr | output | BUS_W | Latched register address |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_wdata | output | BUS_W | Register write data |
| reg_rd | output | 1 | One-cycle register read request |
| reg_rdata | input | BUS_W | Register read data, valid with reg_rvalid |
| reg_rvalid | input | 1 | Read response pulse |

## Verification
The hardest situation to reach is a read response that arrives when no read is waiting for it. A correct bus master never causes it, because it keeps the read strobe low until ready returns. The bench gets there in two ways. First, it starts a read with a long response latency and then withdraws chip select while the block is still waiting, so the delayed response lands in the idle state. Second, it injects a lone response pulse between accesses. After each of these, it runs a normal read and checks that the wait and the data are correct.

// File: rtl/mbs_pkg.sv
// Shared definitions for the multiplexed bus slave.
// Assumes the bit order of the synchronized control vector below is used
// consistently by the top module.
package mbs_pkg;
    // control vector layout after synchronization
    localparam int CTL_W = 4;
    localparam int ALE_B = 3;
    localparam int CS_B  = 2;
    localparam int WR_B  = 1;
    localparam int RD_B  = 0;
    // idle levels: strobe low, active-low controls high
    localparam logic [CTL_W-1:0] CTL_IDLE = 4'b0111;

    // read handshake states
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_HOLD = 2'd2
    } rd_state_e;
endpackage

// File: rtl/mbs_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is treated independently. Multi-bit values are only
// sampled once they have been stable for several cycles.
module mbs_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbs_wr_path.sv
// Address latch and write path. It takes the address on the falling edge
// of the address strobe. On a selected write-strobe rising edge it issues
// one write pulse with the data seen at that edge.
// Assumes the edge flags are single-cycle pulses from synchronized inputs.
module mbs_wr_path #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale_fall,
    input  logic             wr_rise,
    input  logic             cs_n_s,
    input  logic [BUS_W-1:0] ad_s,
    output logic [BUS_W-1:0] reg_addr,
    output logic             reg_wr,
    output logic [BUS_W-1:0] reg_wdata
);
    // hold the address taken at the end of the address phase
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_addr <= '0;
        else if (ale_fall) reg_addr <= ad_s;
    end

    // capture write data and pulse the write strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= wr_rise && !cs_n_s;
            if (wr_rise && !cs_n_s) reg_wdata <= ad_s;
        end
    end

    // R3: the write strobe never lasts more than one cycle
    a_r3_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R4: a write only follows a cycle with chip select low
    a_r4_wr_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(!cs_n_s));
endmodule

// File: rtl/mbs_rd_ctl.sv
// Read handshake controller. It issues the register read request, holds
// ready low until the response arrives, and drives the captured data
// until the read strobe or chip select is released.
// Assumes at most one response per request. Stray responses are dropped.
module mbs_rd_ctl
    import mbs_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_fall,
    input  logic             rd_n_s,
    input  logic             cs_n_s,
    input  logic             rvalid,
    input  logic [BUS_W-1:0] rdata,
    output logic             reg_rd,
    output logic             ad_oe,
    output logic [BUS_W-1:0] ad_out,
    output logic             rdy_out
);
    rd_state_e state;
    logic [BUS_W-1:0] rdata_q;

    // step the read handshake and hold the returned data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            reg_rd  <= 1'b0;
            rdata_q <= '0;
        end else begin
            reg_rd <= 1'b0;
            unique case (state)
                RD_IDLE: if (rd_fall && !cs_n_s) begin
                    state  <= RD_WAIT;
                    reg_rd <= 1'b1;
                end
                RD_WAIT: if (cs_n_s || rd_n_s) begin
                    state <= RD_IDLE;
                end else if (rvalid) begin
                    state   <= RD_HOLD;
                    rdata_q <= rdata;
                end
                RD_HOLD: if (cs_n_s || rd_n_s) state <= RD_IDLE;
                default: state <= RD_IDLE;
            endcase
        end
    end

    // decode pad controls from the handshake state
    always_comb begin
        ad_oe   = (state != RD_IDLE);
        rdy_out = (state != RD_WAIT);
        ad_out  = rdata_q;
    end

    // R5: one request per read strobe
    a_r5_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R6: ready is low while the request is outstanding
    a_r6_rdy_low_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !rdy_out);
    // R7: ready only rises with data driven after a response arrived
    a_r7_rdy_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_out) && ad_oe) |-> $past(rvalid));
    // R8: the lines are driven only after a cycle with select and read low
    a_r8_oe_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!cs_n_s && !rd_n_s));
endmodule

// File: rtl/mux_bus_slave.sv
// Register slave for a processor bus with shared address and data lines.
// It synchronizes all bus inputs, finds the strobe edges, and connects the
// address/write path and the read handshake to a register-file port.
// Assumes the bus strobes last several system clock cycles.
module mux_bus_slave
    import mbs_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ale,
    input  logic             bus_cs_n,
    input  logic             bus_wr_n,
    input  logic             bus_rd_n,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe,
    output logic             bus_rdy,
    output logic             bus_rdy_oe,
    output logic [BUS_W-1:0] reg_addr,
    output logic             reg_wr,
    output logic [BUS_W-1:0] reg_wdata,
    output logic             reg_rd,
    input  logic [BUS_W-1:0] reg_rdata,
    input  logic             reg_rvalid
);
    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic [BUS_W-1:0] ad_s;
    logic             ale_prev, wr_prev, rd_prev;
    logic             ale_fall, wr_rise, rd_fall;

    assign ctl_raw = {bus_ale, bus_cs_n, bus_wr_n, bus_rd_n};

    mbs_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    mbs_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_ad_in), .q(ad_s)
    );

    // keep last synchronized strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_prev <= CTL_IDLE[ALE_B];
            wr_prev  <= CTL_IDLE[WR_B];
            rd_prev  <= CTL_IDLE[RD_B];
        end else begin
            ale_prev <= ctl_s[ALE_B];
            wr_prev  <= ctl_s[WR_B];
            rd_prev  <= ctl_s[RD_B];
        end
    end

    // strobe edges from consecutive samples
    always_comb begin
        ale_fall = ale_prev  && !ctl_s[ALE_B];
        wr_rise  = !wr_prev  &&  ctl_s[WR_B];
        rd_fall  = rd_prev   && !ctl_s[RD_B];
    end

    mbs_wr_path #(.BUS_W(BUS_W)) u_wr_path (
        .clk(clk), .rst_n(rst_n),
        .ale_fall(ale_fall), .wr_rise(wr_rise), .cs_n_s(ctl_s[CS_B]),
        .ad_s(ad_s), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );

    mbs_rd_ctl #(.BUS_W(BUS_W)) u_rd_ctl (
        .clk(clk), .rst_n(rst_n),
        .rd_fall(rd_fall), .rd_n_s(ctl_s[RD_B]), .cs_n_s(ctl_s[CS_B]),
        .rvalid(reg_rvalid), .rdata(reg_rdata),
        .reg_rd(reg_rd), .ad_oe(bus_ad_oe), .ad_out(bus_ad_out), .rdy_out(bus_rdy)
    );

    // ready pad is enabled while the device is selected
    assign bus_rdy_oe = !ctl_s[CS_B];

    // R12: a write and a read request never coincide
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

// File: tb/tb_mux_bus_slave.sv
module tb_mux_bus_slave;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_ale = 1'b0, bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [W-1:0] bus_ad_in = '0;
    logic [W-1:0] bus_ad_out, reg_addr, reg_wdata;
    logic         bus_ad_oe, bus_rdy, bus_rdy_oe, reg_wr, reg_rd;
    logic [W-1:0] reg_rdata = '0;
    logic         reg_rvalid = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mux_bus_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_ad_in(bus_ad_in),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_rdy(bus_rdy),
        .bus_rdy_oe(bus_rdy_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid)
    );

    // register file model and independent expectation
    logic [W-1:0] mem [256];
    logic [W-1:0] exp_mem [256];
    int  lat_cur = 0;
    int  cnt = 0;
    bit  pend = 0;
    bit  stray_req = 0;

    initial for (int i = 0; i < 256; i++) begin
        mem[i] = W'(i) ^ 8'h5A;
        exp_mem[i] = W'(i) ^ 8'h5A;
    end

    // responder: answers a read request after lat_cur extra cycles
    always @(posedge clk) begin
        reg_rvalid <= 1'b0;
        if (stray_req) begin
            reg_rvalid <= 1'b1;
            reg_rdata  <= 8'hEE;
        end else if (reg_rd) begin
            pend <= 1'b1;
            cnt  <= lat_cur;
        end else if (pend) begin
            if (cnt == 0) begin
                reg_rvalid <= 1'b1;
                reg_rdata  <= mem[reg_addr];
                pend <= 1'b0;
            end else cnt <= cnt - 1;
        end
        if (reg_wr) mem[reg_addr] <= reg_wdata;
    end

    // port monitor for strobes
    int n_wr = 0, n_rd = 0;
    logic [W-1:0] wr_addr_seen, wr_data_seen, rd_addr_seen;
    always @(negedge clk) begin
        if (reg_wr) begin n_wr++; wr_addr_seen = reg_addr; wr_data_seen = reg_wdata; end
        if (reg_rd) begin n_rd++; rd_addr_seen = reg_addr; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [W-1:0] a);
        bus_ad_in = a; bus_ale = 1'b1; ncyc(3);
        bus_ale = 1'b0; ncyc(3);
        bus_ad_in = ~a;                     // R2: lines move after the latch edge
    endtask

    task automatic do_write(input logic [W-1:0] a, input logic [W-1:0] d, input bit sel);
        int w0;
        w0 = n_wr;
        if (!sel) bus_cs_n = 1'b1;
        addr_phase(a);
        bus_ad_in = d; bus_wr_n = 1'b0; ncyc(3);
        bus_wr_n = 1'b1; ncyc(5);
        if (sel) begin
            chk(n_wr == w0 + 1, "R3 write pulse count", n_wr - w0, 1);
            chk(wr_addr_seen == a, "R2 write address", wr_addr_seen, a);
            chk(wr_data_seen == d, "R3 write data", wr_data_seen, d);
            exp_mem[a] = d;
        end else begin
            chk(n_wr == w0, "R4 unselected write", n_wr - w0, 0);
        end
        bus_cs_n = 1'b0; ncyc(2);
    endtask

    task automatic do_read(input logic [W-1:0] a, input int lat);
        int r0;
        bit up;
        r0 = n_rd; lat_cur = lat;
        addr_phase(a);
        bus_rd_n = 1'b0; ncyc(4);
        chk(bus_rdy == 1'b0, "R6 ready low while waiting", bus_rdy, 0);
        chk(n_rd == r0 + 1, "R5 read request count", n_rd - r0, 1);
        chk(rd_addr_seen == a, "R2 read address", rd_addr_seen, a);
        up = 0;
        for (int i = 0; i < lat + 30; i++) begin
            if (bus_rdy) begin up = 1; break; end
            @(negedge clk);
        end
        chk(up && bus_ad_oe, "R7 ready and drive after response", {bus_rdy, bus_ad_oe}, 2'b11);
        chk(bus_ad_out == exp_mem[a], "R7 read data", bus_ad_out, exp_mem[a]);
        bus_rd_n = 1'b1; ncyc(4);
        chk(bus_ad_oe == 1'b0, "R8 release after read", bus_ad_oe, 0);
        ncyc(2);
    endtask

    // {write, addr, data, latency}
    localparam logic [24:0] VEC [16] = '{
        {1'b1, 8'h10, 8'hA1, 8'd0}, {1'b0, 8'h10, 8'h00, 8'd0},
        {1'b0, 8'h3C, 8'h00, 8'd7}, {1'b1, 8'hFF, 8'h00, 8'd0},
        {1'b0, 8'hFF, 8'h00, 8'd2}, {1'b1, 8'h00, 8'hFF, 8'd0},
        {1'b0, 8'h00, 8'h00, 8'd15}, {1'b1, 8'h10, 8'h5B, 8'd0},
        {1'b0, 8'h10, 8'h00, 8'd1}, {1'b0, 8'h81, 8'h00, 8'd0},
        {1'b1, 8'h81, 8'h7E, 8'd0}, {1'b1, 8'h82, 8'h81, 8'd0},
        {1'b0, 8'h82, 8'h00, 8'd33}, {1'b0, 8'h81, 8'h00, 8'd4},
        {1'b0, 8'hAA, 8'h00, 8'd11}, {1'b0, 8'h55, 8'h00, 8'd3}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int w0, r0, nw, nr;
        // R1: reset holds pads off even with select low
        bus_cs_n = 1'b0;
        ncyc(5);
        chk(!bus_ad_oe && !bus_rdy_oe, "R1 pads off in reset", {bus_ad_oe, bus_rdy_oe}, 0);
        bus_cs_n = 1'b1;
        ncyc(1); rst_n = 1'b1; ncyc(4);
        chk({bus_ad_oe, bus_rdy_oe, reg_wr, reg_rd} == 4'b0, "R1 idle after reset",
            {bus_ad_oe, bus_rdy_oe, reg_wr, reg_rd}, 0);
        bus_cs_n = 1'b0; ncyc(4);
        chk(bus_rdy_oe == 1'b1, "R9 ready enabled when selected", bus_rdy_oe, 1);

        // R12: vector walk with chip select held low throughout
        w0 = n_wr; r0 = n_rd; nw = 0; nr = 0;
        foreach (VEC[i]) begin
            if (VEC[i][24]) begin do_write(VEC[i][23:16], VEC[i][15:8], 1'b1); nw++; end
            else            begin do_read(VEC[i][23:16], int'(VEC[i][7:0])); nr++; end
        end
        chk(n_wr - w0 == nw, "R12 writes back-to-back", n_wr - w0, nw);
        chk(n_rd - r0 == nr, "R12 reads back-to-back", n_rd - r0, nr);

        // R4: unselected write leaves the register unchanged
        do_write(8'h10, 8'h00, 1'b0);
        do_read(8'h10, 1);

        // R11: abort a waiting read by dropping select
        lat_cur = 60;
        addr_phase(8'h3C);
        bus_rd_n = 1'b0; ncyc(4);
        chk(bus_rdy == 1'b0, "R6 ready low before abort", bus_rdy, 0);
        bus_cs_n = 1'b1; ncyc(4);
        chk(!bus_ad_oe && !bus_rdy_oe, "R11 abort releases pads", {bus_ad_oe, bus_rdy_oe}, 0);
        bus_rd_n = 1'b1;
        bus_cs_n = 1'b0; ncyc(70);
        // R10: late response landed while idle
        chk(bus_ad_oe == 1'b0, "R10 late response ignored", bus_ad_oe, 0);
        chk(bus_rdy == 1'b1, "R10 ready stays high when idle", bus_rdy, 1);
        do_read(8'h3C, 9);

        // R10: injected stray response between accesses
        stray_req = 1'b1; ncyc(1); stray_req = 1'b0; ncyc(3);
        chk(bus_ad_oe == 1'b0, "R10 stray response no drive", bus_ad_oe, 0);
        do_read(8'h81, 6);

        // R9: deselect turns the ready pad off
        bus_cs_n = 1'b1; ncyc(4);
        chk(bus_rdy_oe == 1'b0, "R9 ready off when deselected", bus_rdy_oe, 0);

        finish_run();
    end
endmodule